// File: doc/BRIEF.md
# Address-Latched ROM Bank Mapper

This block sits on the cartridge side of a CPU bus with a 21-bit physical address. It claims the lower 1 MiB of that space as the cartridge window and turns each CPU access there into an address into a 2 MiB ROM. The lower half of the window always shows the first 512 KiB of the ROM. The upper half is a switchable window that shows any one of four 512 KiB banks.

The bank is chosen by where a write goes, not by what it carries. A write to one of four trigger addresses latches the low two bits of that address as the bank number. The block therefore has no data input. The trigger addresses lie inside the fixed region, so a read of them still returns ordinary ROM contents. The current bank feeds the ROM address combinationally, so a read in the cycle after a trigger write already sees the new bank. All enables are active low.

Top module: `rom_bank_mapper`

## Requirements
- R1: `cart_sel_n` is low exactly when `cpu_addr[20]` is 0, whatever the access type.
- R2: For a cartridge address with `cpu_addr[19]` = 0, `rom_addr` equals {2'b00, `cpu_addr[18:0]`}, whatever bank is selected.
- R3: For a cartridge address with `cpu_addr[19]` = 1, `rom_addr` equals {bank, `cpu_addr[18:0]`}, where bank is the two-bit selected bank.
- R4: A write (`cpu_wr_n` low) with `cpu_addr` in 0x001FF0 to 0x001FF3 sets the bank to `cpu_addr[1:0]` at that clock edge.
- R5: A read of 0x001FF0 to 0x001FF3 drives `rom_en_n` low with `rom_addr` equal to the CPU address, and leaves the bank unchanged.
- R6: A write to any other address, including 0x001FF4 and any address with `cpu_addr[20]` = 1 whose low bits match a trigger, leaves the bank unchanged.
- R7: After reset the bank is 0, so the switchable window shows the same ROM bytes as the fixed region.
- R8: A read of the switchable window in the cycle right after a trigger write returns an address in the newly selected bank.
- R9: `rom_en_n` is low only for reads (`cpu_wr_n` high) with `cpu_addr[20]` = 0; every write and every access outside the window keeps it high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 21 | CPU physical address |
| cpu_wr_n | input | 1 | Write strobe, active low; high means read |
| cart_sel_n | output | 1 | Cartridge window select, active low |
| rom_en_n | output | 1 | ROM read enable, active low |
| rom_addr | output | 21 | Address into the 2 MiB ROM |

## Verification
The bench builds the block with its default parameters: a 21-bit CPU address, a 19-bit bank offset, a two-bit bank number and a trigger base of 0x001FF0. These put all four banks, the boundary addresses at the top of each half of the window, the address just past the last trigger, and a trigger pattern aliased above the window within a short vector table. It also drives a trigger write followed at once by a window read, and a reset in the middle of a run with a non-zero bank.

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper #(
  parameter int          CPU_AW   = 21,
  parameter int          OFS_W    = 19,
  parameter int          BANK_W   = 2,
  parameter logic [20:0] TRIG_BASE = 21'h001FF0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CPU_AW-1:0]       cpu_addr,
  input  logic                    cpu_wr_n,
  output logic                    cart_sel_n,
  output logic                    rom_en_n,
  output logic [BANK_W+OFS_W-1:0] rom_addr
);

  localparam int ROM_AW = BANK_W + OFS_W;
  localparam int HALF_B = OFS_W;
  localparam int TOP_B  = CPU_AW - 1;

  logic [BANK_W-1:0] bank_q;
  logic              in_cart;
  logic              trig_hit;
  logic              trig_wr;

  assign in_cart  = ~cpu_addr[TOP_B];
  assign trig_hit = cpu_addr[CPU_AW-1:BANK_W] == TRIG_BASE[CPU_AW-1:BANK_W];
  assign trig_wr  = in_cart & ~cpu_wr_n & trig_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (trig_wr) bank_q <= cpu_addr[BANK_W-1:0];
  end

  assign cart_sel_n = ~in_cart;
  assign rom_en_n   = ~(in_cart & cpu_wr_n);
  assign rom_addr   = cpu_addr[HALF_B] ? {bank_q, cpu_addr[OFS_W-1:0]}
                                       : {{BANK_W{1'b0}}, cpu_addr[OFS_W-1:0]};

  assert_outside_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[TOP_B] |-> (cart_sel_n && rom_en_n));

  assert_fixed_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_addr[TOP_B] && !cpu_addr[HALF_B]) |-> (rom_addr[ROM_AW-1:OFS_W] == '0));

  assert_bank_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_addr[TOP_B] && !cpu_wr_n && cpu_addr[CPU_AW-1:BANK_W] == TRIG_BASE[CPU_AW-1:BANK_W])
    |=> (bank_q == $past(cpu_addr[BANK_W-1:0])));

  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_n || cpu_addr[TOP_B] || cpu_addr[CPU_AW-1:BANK_W] != TRIG_BASE[CPU_AW-1:BANK_W])
    |=> $stable(bank_q));

  assert_write_no_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr_n |-> rom_en_n);

endmodule

// File: tb/test_rom_bank_mapper.sv
module test_rom_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] cpu_addr = '0;
  logic        cpu_wr_n = 1'b1;
  logic        cart_sel_n, rom_en_n;
  logic [20:0] rom_addr;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  rom_bank_mapper i_rom_bank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr_n(cpu_wr_n),
    .cart_sel_n(cart_sel_n), .rom_en_n(rom_en_n), .rom_addr(rom_addr));

  // {req[3:0], wr_n, addr[20:0], exp_cart_n, exp_en_n, exp_rom_addr[20:0]}
  localparam int NV = 18;
  localparam logic [48:0] VEC [NV] = '{
    {4'd7, 1'b1, 21'h080123, 1'b0, 1'b0, 21'h000123},  // R7 bank 0 after reset
    {4'd4, 1'b0, 21'h001FF2, 1'b0, 1'b1, 21'h001FF2},  // R4 select bank 2
    {4'd8, 1'b1, 21'h0C0004, 1'b0, 1'b0, 21'h140004},  // R8 next cycle new bank
    {4'd5, 1'b1, 21'h001FF1, 1'b0, 1'b0, 21'h001FF1},  // R5 read trigger
    {4'd5, 1'b1, 21'h080000, 1'b0, 1'b0, 21'h100000},  // R5 bank kept
    {4'd9, 1'b0, 21'h002000, 1'b0, 1'b1, 21'h002000},  // R9 other write
    {4'd6, 1'b1, 21'h0FFFFF, 1'b0, 1'b0, 21'h17FFFF},  // R6 bank kept
    {4'd1, 1'b0, 21'h1FE000, 1'b1, 1'b1, 21'h17E000},  // R1 outside window
    {4'd3, 1'b1, 21'h0A0000, 1'b0, 1'b0, 21'h120000},  // R3
    {4'd4, 1'b0, 21'h001FF3, 1'b0, 1'b1, 21'h001FF3},  // R4 select bank 3
    {4'd2, 1'b1, 21'h07FFFF, 1'b0, 1'b0, 21'h07FFFF},  // R2 fixed top
    {4'd3, 1'b1, 21'h080010, 1'b0, 1'b0, 21'h180010},  // R3 bank 3
    {4'd4, 1'b0, 21'h001FF0, 1'b0, 1'b1, 21'h001FF0},  // R4 select bank 0
    {4'd8, 1'b1, 21'h0FFFF0, 1'b0, 1'b0, 21'h07FFF0},  // R8
    {4'd6, 1'b0, 21'h101FF1, 1'b1, 1'b1, 21'h001FF1},  // R6 aliased trigger above window
    {4'd6, 1'b1, 21'h080001, 1'b0, 1'b0, 21'h000001},  // R6 still bank 0
    {4'd6, 1'b0, 21'h001FF4, 1'b0, 1'b1, 21'h001FF4},  // R6 just past triggers
    {4'd6, 1'b1, 21'h0C0000, 1'b0, 1'b0, 21'h040000}   // R6 still bank 0
  };

  task automatic check(input int req, input logic [22:0] act, input logic [22:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got cart_n=%b en_n=%b addr=%h, expected cart_n=%b en_n=%b addr=%h",
               req, act[22], act[21], act[20:0], exp[22], exp[21], exp[20:0]);
    end
  endtask

  task automatic apply(input logic wr_n, input logic [20:0] a);
    @(negedge clk);
    cpu_wr_n = wr_n;
    cpu_addr = a;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(7, {cart_sel_n, rom_en_n, rom_addr}, {1'b0, 1'b0, 21'h000000}); // R7 reset outputs
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][44], VEC[i][43:23]);
      check(int'(VEC[i][48:45]), {cart_sel_n, rom_en_n, rom_addr}, VEC[i][22:0]);
    end
    // R7: reset returns a non-zero bank to 0
    apply(1'b0, 21'h001FF1);
    apply(1'b1, 21'h0E0000);
    check(3, {cart_sel_n, rom_en_n, rom_addr}, {1'b0, 1'b0, 21'h0E0000});
    rst_n = 1'b0;
    #1;
    check(7, {cart_sel_n, rom_en_n, rom_addr}, {1'b0, 1'b0, 21'h060000});
    @(negedge clk);
    rst_n = 1'b1;
    // R8: back-to-back trigger writes, last one wins
    apply(1'b0, 21'h001FF2);
    apply(1'b0, 21'h001FF1);
    apply(1'b1, 21'h080040);
    check(8, {cart_sel_n, rom_en_n, rom_addr}, {1'b0, 1'b0, 21'h080040});
    // R1: read above window leaves ROM idle
    apply(1'b1, 21'h180000);
    check(1, {cart_sel_n, rom_en_n, rom_addr}, {1'b1, 1'b1, 21'h080000});
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule